// File: doc/BRIEF.md
# Five-Stage Integer Pipeline with Exposed Delay Slots

This block is a compact in-order 32-bit integer core. It has five stages: fetch, decode, execute, memory access and writeback. One instruction enters the pipeline on every clock. It runs a small instruction subset:

- load word and store word
- add immediate, add, and shift left logical
- branch-if-equal and an unconditional jump

Control hazards and data hazards are left to software. The core has no stall logic and no result forwarding. Branches and jumps resolve in decode. The one instruction fetched behind a branch or jump (the delay slot) always completes.

Instruction memory and data memory are both synchronous. Read data comes back one clock after the address. The core drives an instruction address every cycle. It issues data accesses from its memory stage and takes load data in writeback. A program that follows the spacing rule below gets the ordinary sequential meaning of its code. A program that breaks the rule sees stale register values, and that outcome is defined and repeatable.

Top module: `pipe5_core`

## Requirements
- R1: While `rst` is high at a clock edge, the fetch address becomes 0 and every pipeline stage holds a bubble, so `dmem_we` is 0 on the following cycle. All general registers are cleared to zero.
- R2: With no jump or branch in decode, the fetch address advances by 4 on every clock. The word returned for the first address after reset is the first instruction executed.
- R3: Encodings use bits [31:26] as the opcode: 0 is register format, 8 add-immediate, 35 load, 43 store, 4 branch-if-equal, 2 jump. Fields are rs [25:21], rt [20:16], rd [15:11], shamt [10:6] and funct [5:0] (32 add, 0 shift-left). The immediate is [15:0] and is sign-extended. The jump index is [25:0].
- R4: Add writes rs+rt to rd. Shift-left writes rt shifted left by shamt to rd. Add-immediate writes rs plus the sign-extended immediate to rt.
- R5: Load and store use the address rs plus the sign-extended immediate. A store drives `dmem_we` with rt's value for one cycle. A loaded word is written to rt.
- R6: There is no forwarding. An instruction reads a register's new value only if at least two instructions separate it from the producer. With zero or one instruction between, it reads the previous value.
- R7: A taken branch-if-equal runs its delay slot. The next fetch is then the delay slot's address plus the immediate times 4. The words between are never fetched.
- R8: A not-taken branch-if-equal runs its delay slot and then continues sequentially.
- R9: A jump runs its delay slot. The next fetch is then the delay slot's address bits [31:28] joined with the index and two zero bits.
- R10: Register 0 always reads as zero. Writes to it have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| imem_addr | output | 32 | Byte address of the instruction being fetched |
| imem_rdata | input | 32 | Instruction word, one cycle after its address |
| dmem_addr | output | 32 | Data byte address from the memory stage |
| dmem_we | output | 1 | Store strobe |
| dmem_wdata | output | 32 | Store data |
| dmem_rdata | input | 32 | Load data, one cycle after its address |

## Verification
The hardest behaviour to observe from the ports is the stale register read inside the hazard window. It leaves no mark of its own and shows only in later stores. The stimulus therefore writes one register and stores it with zero, one and two instructions in between. It expects 0, 0 and the new value.

Branch and jump paths are exposed through the fetch trace. The trace checks that skipped words are never fetched and that delay-slot words always are. A scoreboard of expected stores catches any instruction that ran when it should have been skipped.

// File: rtl/pipe5_pkg.sv
package pipe5_pkg;
    localparam int XLEN    = 32;
    localparam int REG_AW  = 5;
    localparam int NREG    = 1 << REG_AW;
    localparam int OPC_W   = 6;
    localparam int IMM_W   = 16;
    localparam int JIDX_W  = 26;
    localparam int SHAMT_W = 5;

    localparam logic [OPC_W-1:0] OP_RTYPE = 6'd0;
    localparam logic [OPC_W-1:0] OP_J     = 6'd2;
    localparam logic [OPC_W-1:0] OP_BEQ   = 6'd4;
    localparam logic [OPC_W-1:0] OP_ADDI  = 6'd8;
    localparam logic [OPC_W-1:0] OP_LW    = 6'd35;
    localparam logic [OPC_W-1:0] OP_SW    = 6'd43;
    localparam logic [5:0]       FN_SLL   = 6'd0;
    localparam logic [5:0]       FN_ADD   = 6'd32;

    typedef enum logic [0:0] {ALU_ADD = 1'b0, ALU_SLL = 1'b1} alu_op_e;

    typedef struct packed {
        logic              reg_we;
        logic              mem_rd;
        logic              mem_wr;
        alu_op_e           alu_op;
        logic              use_imm;
        logic [REG_AW-1:0] rd;
    } ctrl_t;

    localparam ctrl_t CTRL_NOP = '{reg_we: 1'b0, mem_rd: 1'b0, mem_wr: 1'b0,
                                   alu_op: ALU_ADD, use_imm: 1'b0, rd: '0};

    function automatic logic [XLEN-1:0] sext_imm(input logic [IMM_W-1:0] v);
        return {{(XLEN-IMM_W){v[IMM_W-1]}}, v};
    endfunction
endpackage

// File: rtl/pipe5_decode.sv
module pipe5_decode
    import pipe5_pkg::*;
(
    input  logic [XLEN-1:0]    inst,
    input  logic               valid,
    output ctrl_t              ctrl,
    output logic [REG_AW-1:0]  rs,
    output logic [REG_AW-1:0]  rt,
    output logic [XLEN-1:0]    imm,
    output logic [SHAMT_W-1:0] shamt,
    output logic [JIDX_W-1:0]  jidx,
    output logic               is_beq,
    output logic               is_jmp
);
    logic [OPC_W-1:0]  opc;
    logic [5:0]        funct;
    logic [REG_AW-1:0] rd_f;

    assign opc   = inst[31:26];
    assign rs    = inst[25:21];
    assign rt    = inst[20:16];
    assign rd_f  = inst[15:11];
    assign shamt = inst[10:6];
    assign funct = inst[5:0];
    assign imm   = sext_imm(inst[IMM_W-1:0]);
    assign jidx  = inst[JIDX_W-1:0];

    always_comb begin
        ctrl   = CTRL_NOP;
        is_beq = 1'b0;
        is_jmp = 1'b0;
        if (valid) begin
            case (opc)
                OP_RTYPE: begin
                    if (funct == FN_ADD) begin
                        ctrl.reg_we = 1'b1;
                        ctrl.rd     = rd_f;
                    end else if (funct == FN_SLL) begin
                        ctrl.reg_we = 1'b1;
                        ctrl.alu_op = ALU_SLL;
                        ctrl.rd     = rd_f;
                    end
                end
                OP_ADDI: begin
                    ctrl.reg_we  = 1'b1;
                    ctrl.use_imm = 1'b1;
                    ctrl.rd      = rt;
                end
                OP_LW: begin
                    ctrl.reg_we  = 1'b1;
                    ctrl.mem_rd  = 1'b1;
                    ctrl.use_imm = 1'b1;
                    ctrl.rd      = rt;
                end
                OP_SW: begin
                    ctrl.mem_wr  = 1'b1;
                    ctrl.use_imm = 1'b1;
                end
                OP_BEQ:  is_beq = 1'b1;
                OP_J:    is_jmp = 1'b1;
                default: ;
            endcase
        end
        if (ctrl.rd == '0) ctrl.reg_we = 1'b0;
    end
endmodule

// File: rtl/pipe5_regfile.sv
module pipe5_regfile #(
    parameter int W  = 32,
    parameter int AW = 5,
    localparam int N = 1 << AW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] ra_a,
    input  logic [AW-1:0] ra_b,
    output logic [W-1:0]  rd_a,
    output logic [W-1:0]  rd_b
);
    logic [W-1:0] regs [N];

    assign regs[0] = '0;

    for (genvar g = 1; g < N; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)                         regs[g] <= '0;
            else if (we && waddr == AW'(g))  regs[g] <= wdata;
        end
    end

    // write-before-read: a writeback in this cycle is visible to decode
    always_comb begin
        rd_a = regs[ra_a];
        rd_b = regs[ra_b];
        if (we && waddr != '0 && waddr == ra_a) rd_a = wdata;
        if (we && waddr != '0 && waddr == ra_b) rd_b = wdata;
    end
endmodule

// File: rtl/pipe5_alu.sv
module pipe5_alu
    import pipe5_pkg::*;
(
    input  alu_op_e            op,
    input  logic [XLEN-1:0]    a,
    input  logic [XLEN-1:0]    b,
    input  logic [SHAMT_W-1:0] shamt,
    output logic [XLEN-1:0]    y
);
    always_comb begin
        case (op)
            ALU_SLL: y = b << shamt;
            default: y = a + b;
        endcase
    end
endmodule

// File: rtl/pipe5_core.sv
module pipe5_core
    import pipe5_pkg::*;
#(
    parameter logic [31:0] RESET_PC = 32'h0
) (
    input  logic        clk,
    input  logic        rst,
    output logic [31:0] imem_addr,
    input  logic [31:0] imem_rdata,
    output logic [31:0] dmem_addr,
    output logic        dmem_we,
    output logic [31:0] dmem_wdata,
    input  logic [31:0] dmem_rdata
);
    localparam logic [XLEN-1:0] WORD_BYTES = XLEN'(XLEN / 8);

    // fetch
    logic [XLEN-1:0] pc_q, pc_d;
    logic            id_valid_q;

    // decode
    ctrl_t              id_ctrl;
    logic [REG_AW-1:0]  id_rs, id_rt;
    logic [XLEN-1:0]    id_imm, id_a, id_b;
    logic [SHAMT_W-1:0] id_shamt;
    logic [JIDX_W-1:0]  id_jidx;
    logic               id_beq, id_jmp, id_taken;
    logic [XLEN-1:0]    br_tgt, jmp_tgt;

    // execute
    ctrl_t              ex_ctrl_q;
    logic [XLEN-1:0]    ex_a_q, ex_b_q, ex_imm_q, ex_opb, ex_y;
    logic [SHAMT_W-1:0] ex_shamt_q;

    // memory
    ctrl_t           mem_ctrl_q;
    logic [XLEN-1:0] mem_res_q, mem_sdata_q;

    // writeback
    ctrl_t           wb_ctrl_q;
    logic [XLEN-1:0] wb_res_q, wb_data;

    assign imem_addr = pc_q;

    pipe5_decode u_dec (
        .inst   (imem_rdata),
        .valid  (id_valid_q),
        .ctrl   (id_ctrl),
        .rs     (id_rs),
        .rt     (id_rt),
        .imm    (id_imm),
        .shamt  (id_shamt),
        .jidx   (id_jidx),
        .is_beq (id_beq),
        .is_jmp (id_jmp)
    );

    pipe5_regfile #(.W(XLEN), .AW(REG_AW)) u_rf (
        .clk   (clk),
        .rst   (rst),
        .we    (wb_ctrl_q.reg_we),
        .waddr (wb_ctrl_q.rd),
        .wdata (wb_data),
        .ra_a  (id_rs),
        .ra_b  (id_rt),
        .rd_a  (id_a),
        .rd_b  (id_b)
    );

    // pc_q already holds the delay-slot address while the branch decodes
    assign br_tgt   = pc_q + {id_imm[XLEN-3:0], 2'b00};
    assign jmp_tgt  = {pc_q[XLEN-1:JIDX_W+2], id_jidx, 2'b00};
    assign id_taken = id_beq && (id_a == id_b);

    always_comb begin
        if (id_jmp)        pc_d = jmp_tgt;
        else if (id_taken) pc_d = br_tgt;
        else               pc_d = pc_q + WORD_BYTES;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q       <= RESET_PC;
            id_valid_q <= 1'b0;
        end else begin
            pc_q       <= pc_d;
            id_valid_q <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ex_ctrl_q  <= CTRL_NOP;
            ex_a_q     <= '0;
            ex_b_q     <= '0;
            ex_imm_q   <= '0;
            ex_shamt_q <= '0;
        end else begin
            ex_ctrl_q  <= id_ctrl;
            ex_a_q     <= id_a;
            ex_b_q     <= id_b;
            ex_imm_q   <= id_imm;
            ex_shamt_q <= id_shamt;
        end
    end

    assign ex_opb = ex_ctrl_q.use_imm ? ex_imm_q : ex_b_q;

    pipe5_alu u_alu (
        .op    (ex_ctrl_q.alu_op),
        .a     (ex_a_q),
        .b     (ex_opb),
        .shamt (ex_shamt_q),
        .y     (ex_y)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            mem_ctrl_q  <= CTRL_NOP;
            mem_res_q   <= '0;
            mem_sdata_q <= '0;
        end else begin
            mem_ctrl_q  <= ex_ctrl_q;
            mem_res_q   <= ex_y;
            mem_sdata_q <= ex_b_q;
        end
    end

    assign dmem_addr  = mem_res_q;
    assign dmem_we    = mem_ctrl_q.mem_wr;
    assign dmem_wdata = mem_sdata_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            wb_ctrl_q <= CTRL_NOP;
            wb_res_q  <= '0;
        end else begin
            wb_ctrl_q <= mem_ctrl_q;
            wb_res_q  <= mem_res_q;
        end
    end

    assign wb_data = wb_ctrl_q.mem_rd ? dmem_rdata : wb_res_q;
endmodule

// File: rtl/pipe5_core_chk.sv
module pipe5_core_chk #(
    parameter logic [31:0] START = 32'h0
) (
    input logic        clk,
    input logic        rst,
    input logic [31:0] imem_addr,
    input logic [31:0] imem_rdata,
    input logic        dmem_we,
    input logic        dec_beq,
    input logic        dec_jmp,
    input logic [4:0]  dec_rs,
    input logic [31:0] rs_val
);
    // R1
    reset_fetch_chk: assert property (@(posedge clk) rst |=> imem_addr == START);

    // R1
    reset_store_chk: assert property (@(posedge clk) rst |=> !dmem_we);

    // R2
    seq_fetch_chk: assert property (@(posedge clk) disable iff (rst)
        !(dec_beq || dec_jmp) |=> imem_addr == $past(imem_addr) + 32'd4);

    // R9
    jump_target_chk: assert property (@(posedge clk) disable iff (rst)
        dec_jmp |=> imem_addr == {$past(imem_addr[31:28]), $past(imem_rdata[25:0]), 2'b00});

    // R7
    branch_target_chk: assert property (@(posedge clk) disable iff (rst)
        dec_beq |=> (imem_addr == $past(imem_addr) + 32'd4) ||
                    (imem_addr == $past(imem_addr) +
                        {{14{$past(imem_rdata[15])}}, $past(imem_rdata[15:0]), 2'b00}));

    // R10
    zero_reg_chk: assert property (@(posedge clk) disable iff (rst)
        dec_rs == 5'd0 |-> rs_val == 32'd0);
endmodule

bind pipe5_core pipe5_core_chk #(.START(RESET_PC)) chk_i (
    .clk        (clk),
    .rst        (rst),
    .imem_addr  (imem_addr),
    .imem_rdata (imem_rdata),
    .dmem_we    (dmem_we),
    .dec_beq    (id_beq),
    .dec_jmp    (id_jmp),
    .dec_rs     (id_rs),
    .rs_val     (id_a)
);

// File: tb/pipe5_core_tb_top.sv
`timescale 1ns/1ps
module pipe5_core_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] imem_addr, imem_rdata, dmem_addr, dmem_wdata, dmem_rdata;
    logic        dmem_we;

    always #2.5 clk = ~clk;

    pipe5_core dut_i (
        .clk        (clk),
        .rst        (rst),
        .imem_addr  (imem_addr),
        .imem_rdata (imem_rdata),
        .dmem_addr  (dmem_addr),
        .dmem_we    (dmem_we),
        .dmem_wdata (dmem_wdata),
        .dmem_rdata (dmem_rdata)
    );

    logic [31:0] imem [64];
    logic [31:0] dmem [64];
    logic        seen [64];

    always @(posedge clk) begin
        imem_rdata <= imem[imem_addr[7:2]];
        dmem_rdata <= dmem[dmem_addr[7:2]];
        if (dmem_we) dmem[dmem_addr[7:2]] <= dmem_wdata;
    end

    int n_chk  = 0;
    int n_fail = 0;

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // encoders (R3)
    function automatic logic [31:0] enc_r(input int rs, input int rt, input int rd,
                                          input int sh, input int fn);
        return {6'd0, 5'(rs), 5'(rt), 5'(rd), 5'(sh), 6'(fn)};
    endfunction
    function automatic logic [31:0] enc_i(input int op, input int rs, input int rt,
                                          input int imm);
        return {6'(op), 5'(rs), 5'(rt), 16'(imm)};
    endfunction
    function automatic logic [31:0] enc_j(input int idx);
        return {6'd2, 26'(idx)};
    endfunction

    typedef struct {
        logic [31:0] addr;
        logic [31:0] data;
        string       req;
    } store_t;
    store_t exp_q [$];

    task automatic expect_store(input logic [31:0] a, input logic [31:0] d, input string r);
        store_t s;
        s.addr = a; s.data = d; s.req = r;
        exp_q.push_back(s);
    endtask

    // monitor: compare every store against the scoreboard, record fetches
    always @(negedge clk) begin
        if (!rst) begin
            seen[imem_addr[7:2]] = 1'b1;
            if (dmem_we) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R7/R8/R9 unexpected store", dmem_addr, 32'hFFFFFFFF);
                end else begin
                    store_t s;
                    s = exp_q.pop_front();
                    check(dmem_addr == s.addr, {s.req, " addr"}, dmem_addr, s.addr);
                    check(dmem_wdata == s.data, {s.req, " data"}, dmem_wdata, s.data);
                end
            end
        end
    end

    initial begin
        for (int i = 0; i < 64; i++) begin
            imem[i] = 32'd0;
            dmem[i] = 32'd0;
            seen[i] = 1'b0;
        end
        dmem[1] = 32'd7;
        dmem[2] = 32'd7;
        dmem[3] = 32'd9;

        imem[0]  = enc_i(35, 0, 1, 4);       // lw r1 <- 7
        imem[1]  = enc_i(35, 0, 2, 8);       // lw r2 <- 7
        imem[2]  = enc_i(35, 0, 6, 12);      // lw r6 <- 9
        imem[3]  = enc_i(8, 0, 3, 3);        // r3 = 3
        imem[4]  = enc_i(8, 0, 4, -4);       // r4 = -4
        imem[5]  = enc_i(4, 1, 2, 3);        // beq taken -> 9
        imem[6]  = enc_i(8, 0, 5, 5);        // delay slot r5 = 5
        imem[7]  = enc_i(43, 0, 4, 16);      // skipped
        imem[8]  = enc_i(43, 0, 4, 16);      // skipped
        imem[9]  = 32'd0;
        imem[10] = enc_i(43, 0, 3, 16);
        imem[11] = enc_i(43, 0, 5, 20);
        imem[12] = enc_i(4, 1, 6, 7);        // beq not taken
        imem[13] = enc_i(8, 0, 7, 256);      // delay slot
        imem[14] = enc_r(1, 6, 8, 0, 32);    // r8 = 16
        imem[15] = enc_r(0, 6, 9, 4, 0);     // r9 = 9<<4
        imem[16] = enc_i(43, 0, 7, 24);
        imem[17] = enc_i(43, 0, 8, 28);
        imem[18] = enc_i(43, 0, 9, 32);
        imem[19] = enc_j(23);
        imem[20] = enc_i(43, 0, 8, 36);      // jump delay slot
        imem[21] = enc_i(43, 0, 9, 36);      // skipped
        imem[22] = enc_i(43, 0, 9, 40);      // skipped
        imem[23] = enc_i(8, 0, 10, 11);      // r10 = 11
        imem[24] = enc_i(43, 0, 10, 40);     // zero between: old
        imem[25] = enc_i(43, 0, 10, 44);     // one between: old
        imem[26] = enc_i(43, 0, 10, 48);     // two between: new
        imem[27] = enc_i(8, 0, 0, 55);       // write r0
        imem[28] = enc_i(43, 0, 4, 60);
        imem[29] = 32'd0;
        imem[30] = enc_i(43, 0, 0, 52);
        imem[31] = enc_i(35, 0, 11, 4);      // lw r11 <- 7
        imem[32] = 32'd0;
        imem[33] = 32'd0;
        imem[34] = enc_i(43, 0, 11, 56);
        imem[35] = enc_i(8, 0, 12, 8);       // r12 = 8
        imem[36] = 32'd0;
        imem[37] = 32'd0;
        imem[38] = enc_i(43, 12, 3, -4);     // store 3 @ 4
        imem[39] = enc_j(39);
        imem[40] = 32'd0;

        expect_store(32'd16, 32'd3, "R7 taken target");
        expect_store(32'd20, 32'd5, "R7 branch delay slot");
        expect_store(32'd24, 32'd256, "R8 not-taken delay slot");
        expect_store(32'd28, 32'd16, "R4 add");
        expect_store(32'd32, 32'd144, "R4 shift left");
        expect_store(32'd36, 32'd16, "R9 jump delay slot");
        expect_store(32'd40, 32'd0, "R6 adjacent stale");
        expect_store(32'd44, 32'd0, "R6 one-gap stale");
        expect_store(32'd48, 32'd11, "R6 two-gap fresh");
        expect_store(32'd60, 32'hFFFFFFFC, "R4 sign-extended imm");
        expect_store(32'd52, 32'd0, "R10 zero register");
        expect_store(32'd56, 32'd7, "R5 load writeback");
        expect_store(32'd4, 32'd3, "R5 base plus negative offset");

        repeat (3) @(posedge clk);
        @(negedge clk);
        check(imem_addr == 32'd0, "R1 reset fetch address", imem_addr, 32'd0);
        check(dmem_we == 1'b0, "R1 reset store strobe", {31'd0, dmem_we}, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        check(imem_addr == 32'd4, "R2 sequential fetch", imem_addr, 32'd4);
        @(negedge clk);
        check(imem_addr == 32'd8, "R2 sequential fetch", imem_addr, 32'd8);

        begin
            int cyc = 0;
            while (exp_q.size() != 0 && cyc < 2000) begin
                @(negedge clk);
                cyc++;
            end
            if (exp_q.size() != 0)
                check(1'b0, "watchdog: stores outstanding", exp_q.size(), 32'd0);
        end
        repeat (20) @(negedge clk);

        check(seen[6] == 1'b1, "R7 delay slot fetched", {31'd0, seen[6]}, 32'd1);
        check(seen[7] == 1'b0, "R7 skipped word 7", {31'd0, seen[7]}, 32'd0);
        check(seen[8] == 1'b0, "R7 skipped word 8", {31'd0, seen[8]}, 32'd0);
        check(seen[14] == 1'b1, "R8 sequential after slot", {31'd0, seen[14]}, 32'd1);
        check(seen[21] == 1'b0, "R9 skipped word 21", {31'd0, seen[21]}, 32'd0);
        check(seen[22] == 1'b0, "R9 skipped word 22", {31'd0, seen[22]}, 32'd0);
        check(dmem[13] == 32'd0, "R10 r0 write ignored", dmem[13], 32'd0);
        check(dmem[9] == 32'd16, "R9 slot store landed", dmem[9], 32'd16);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule